// File: doc/BRIEF.md
# Serial SAR Converter Control Sequencer

This block is the digital side of an 8-bit successive-approximation converter with a serial host link. A host selects the block by pulling `cs_n` low. It then clocks an address word into `di`: any number of leading zeros, a one as the start bit, and the channel bits MSB first. Once the start bit reaches the top of the address register, the channel is latched and presented on `chan_code`. The block then waits a programmable sampling interval and raises `sars`. It then runs one comparison per clock. In each step it presents a trial code on `trial_code` to the external DAC and comparator, and it keeps or drops the trial bit according to the `comp` input.

Each decided bit goes out on the serial output at the next falling clock edge, so the word leaves MSB first while the conversion is still running. The output is a data bit `do_val` qualified by an enable `do_en`. The pad buffer that turns these into a tri-state line sits outside the block.

After the last step, `sars` stays high for one more clock and the finished word is copied into an output shift register. A build-time mode then selects what follows:
- Paced mode: `se` low advances the word LSB first, one bit per clock, and `se` high holds the current bit.
- Automatic mode: the LSB-first word follows the MSB-first word with no gap.
- MSB-only mode: the LSB-first phase is skipped.

In every mode the line is driven low after the last bit and stays low until `cs_n` returns high. Raising `cs_n` clears every register at once and floats the line. The serial link is a plain clocked protocol with no back-pressure: the host must take each bit in the clock it appears. `di` is only looked at while `do_en` is low, so the two pins may share one host wire.

Top module: `sar_serial_seq`

## Requirements
- R1: While `cs_n` is low and no address has completed, zeros on `di` are ignored. The first one sampled is the start bit, and the next CH_W samples are the channel, MSB first. From the clock that samples the last channel bit, `chan_code` shows that channel; before then it reads 0.
- R2: SAMP_CYC clocks after the channel is latched, `sars` rises.
- R3: `sars` stays high for exactly W+1 clocks: W comparison steps plus one.
- R4: After the address has completed, `di` has no effect. `chan_code` holds its value, and the result word on the serial output matches the comparator decisions, whatever `di` does.
- R5: `do_en` is 0 until the conversion starts. At the falling edge after `sars` rises, `do_en` becomes 1 and `do_val` is 0 (the leading zero). `do_en` then stays 1 until `cs_n` rises.
- R6: During step i (i = W-1 down to 0, one per clock), `trial_code` holds the bits already decided above i, a 1 at bit i, and zeros below. At the end of the step, bit i is kept at 1 when `comp` is 1 and cleared when it is 0. Outside the conversion, `trial_code` is 0.
- R7: Each decided bit appears on `do_val` at the falling edge after the rising edge that decides it. Bit W-1 comes first and bit 0 last. Bit 0 is on the line while `sars` is still high in its final clock.
- R8: Paced mode: from the rising edge that ends the final `sars` clock, each rising edge with `se` low moves the line to the next bit, bit 1 up to bit W-1, and one more such edge drives 0. Rising edges with `se` high leave the line unchanged. Before that point, `se` has no effect.
- R9: Automatic mode: bits 1 through W-1 follow bit 0 on successive falling edges. After them the line is driven 0 until `cs_n` rises.
- R10: MSB-only mode: after bit 0, the line is driven 0 until `cs_n` rises.
- R11: Raising `cs_n` clears `do_en`, `do_val`, `sars`, `trial_code` and `chan_code` at once, without waiting for a clock. A new conversion then needs a new falling edge of `cs_n` and a complete new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial and conversion clock |
| cs_n | input | 1 | Active-low select; high clears the block asynchronously |
| di | input | 1 | Serial address input, sampled on rising edges |
| comp | input | 1 | Comparator decision for the current trial code (1 keeps the bit) |
| se | input | 1 | LSB-first pacing in paced mode; low advances, high holds |
| sars | output | 1 | High while the conversion runs and for one clock after |
| do_en | output | 1 | Serial output enable for the external pad buffer |
| do_val | output | 1 | Serial output data, updated on falling edges |
| chan_code | output | CH_W | Latched channel select for the input multiplexer |
| trial_code | output | W | Trial code for the DAC during the conversion |

## Verification
A wrong phase or step count shows up at once: `sars` rises or falls a clock early or late, and the output enable comes up at the wrong falling edge. A SAR register that keeps or drops the wrong bit alters `trial_code` in the very next clock. It also puts a wrong bit on `do_val` half a clock later, and the same wrong bit comes back in the LSB-first replay. A faulty output shift register or shift counter only shows after the conversion: as a wrong or repeated bit on the line, or as the final low level arriving too early or too late. Faults in the asynchronous clear show in the first sample after `cs_n` rises.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

  typedef enum logic [2:0] {
    ST_ADDR,
    ST_SAMP,
    ST_CONV,
    ST_TAIL,
    ST_SHIFT,
    ST_DONE
  } phase_e;

  typedef enum logic [1:0] {
    LSB_PACED,
    LSB_AUTO,
    MSB_ONLY
  } lsb_mode_e;

endpackage

// File: rtl/sarseq_addr_rx.sv
module sarseq_addr_rx #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            cs_n,
  input  logic            take,
  input  logic            di,
  output logic            lock,
  output logic [CH_W-1:0] chan
);

  logic [CH_W:0] addr_q;
  logic [CH_W:0] addr_d;

  assign addr_d = {addr_q[CH_W-1:0], di};
  // the start bit has reached the top slot: the address is complete
  assign lock   = take & addr_d[CH_W];

  always_ff @(posedge clk or posedge cs_n) begin
    if (cs_n) begin
      addr_q <= '0;
      chan   <= '0;
    end else if (take) begin
      addr_q <= addr_d;
      if (addr_d[CH_W]) chan <= addr_d[CH_W-1:0];
    end
  end

  // R4: once address intake has stopped, the channel must not move
  p_chan_hold_r4: assert property (@(posedge clk) disable iff (cs_n)
    !take |=> $stable(chan));

endmodule

// File: rtl/sarseq_fsm.sv
module sarseq_fsm
  import sarseq_pkg::*;
#(
  parameter int        W        = 8,
  parameter int        BW       = 3,
  parameter int        SAMP_CYC = 1,
  parameter lsb_mode_e MODE     = LSB_PACED
) (
  input  logic          clk,
  input  logic          cs_n,
  input  logic          lock,
  input  logic          se,
  output phase_e        phase,
  output logic [BW-1:0] bidx,
  output logic          sars,
  output logic          take,
  output logic          go_conv,
  output logic          conv,
  output logic          last_step,
  output logic          adv,
  output logic          fin_shift
);

  localparam int SCW = $clog2(SAMP_CYC + 1);

  logic [SCW-1:0] scnt;
  logic [BW-1:0]  sh_cnt;

  assign take      = (phase == ST_ADDR);
  assign conv      = (phase == ST_CONV);
  assign sars      = (phase == ST_CONV) || (phase == ST_TAIL);
  assign go_conv   = (phase == ST_SAMP) && (scnt == SCW'(SAMP_CYC - 1));
  assign last_step = conv && (bidx == '0);
  assign adv       = ((phase == ST_TAIL) || (phase == ST_SHIFT)) &&
                     (MODE != MSB_ONLY) && ((MODE == LSB_AUTO) || !se);
  assign fin_shift = adv && (phase == ST_SHIFT) && (sh_cnt == BW'(W - 1));

  always_ff @(posedge clk or posedge cs_n) begin
    if (cs_n) begin
      phase  <= ST_ADDR;
      bidx   <= '0;
      scnt   <= '0;
      sh_cnt <= '0;
    end else begin
      unique case (phase)
        ST_ADDR: if (lock) begin
          phase <= ST_SAMP;
          scnt  <= '0;
        end
        ST_SAMP: begin
          if (go_conv) begin
            phase <= ST_CONV;
            bidx  <= BW'(W - 1);
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (bidx == '0) phase <= ST_TAIL;
          else            bidx  <= bidx - 1'b1;
        end
        ST_TAIL: begin
          phase <= (MODE == MSB_ONLY) ? ST_DONE : ST_SHIFT;
          if (adv) sh_cnt <= sh_cnt + 1'b1;
        end
        ST_SHIFT: begin
          if (adv) begin
            if (fin_shift) phase  <= ST_DONE;
            else           sh_cnt <= sh_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: the status flag only rises out of the sampling interval
  p_rise_after_samp_r2: assert property (@(posedge clk) disable iff (cs_n)
    $rose(sars) |-> ($past(phase) == ST_SAMP));

  // R3: the status flag only falls after the extra clock past the last step
  p_fall_after_tail_r3: assert property (@(posedge clk) disable iff (cs_n)
    $fell(sars) |-> ($past(phase) == ST_TAIL));

endmodule

// File: rtl/sarseq_sar.sv
module sarseq_sar #(
  parameter int W  = 8,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          cs_n,
  input  logic          conv,
  input  logic [BW-1:0] bidx,
  input  logic          comp,
  output logic [W-1:0]  trial,
  output logic [W-2:0]  upper
);

  logic [W-1:0] sar_q;
  logic [W-1:0] probe;

  assign probe = {{(W-1){1'b0}}, 1'b1} << bidx;
  assign trial = conv ? (sar_q | probe) : '0;
  assign upper = sar_q[W-1:1];

  always_ff @(posedge clk or posedge cs_n) begin
    if (cs_n)      sar_q       <= '0;
    else if (conv) sar_q[bidx] <= comp;
  end

  // R6: bits decided two or more steps back stay fixed in the trial code
  p_upper_kept_r6: assert property (@(posedge clk) disable iff (cs_n)
    (conv && $past(conv)) |->
      ((trial >> (int'(bidx) + 2)) == ($past(trial) >> (int'(bidx) + 2))));

endmodule

// File: rtl/sarseq_dout.sv
module sarseq_dout
  import sarseq_pkg::*;
#(
  parameter int        W    = 8,
  parameter lsb_mode_e MODE = LSB_PACED
) (
  input  logic         clk,
  input  logic         cs_n,
  input  phase_e       phase,
  input  logic         go_conv,
  input  logic         last_step,
  input  logic         comp,
  input  logic [W-2:0] upper,
  input  logic         adv,
  input  logic         fin_shift,
  output logic         do_en,
  output logic         do_val
);

  logic         oe_r;
  logic         dv_r;
  logic [W-2:0] lsbq;

  // rising-edge side: decide what the line carries next
  always_ff @(posedge clk or posedge cs_n) begin
    if (cs_n) begin
      oe_r <= 1'b0;
      dv_r <= 1'b0;
      lsbq <= '0;
    end else begin
      if (go_conv) begin
        oe_r <= 1'b1;
        dv_r <= 1'b0;
      end
      if (phase == ST_CONV) begin
        dv_r <= comp;
        if (last_step) lsbq <= upper;
      end
      if ((phase == ST_TAIL) && (MODE == MSB_ONLY)) dv_r <= 1'b0;
      if (adv) begin
        dv_r <= fin_shift ? 1'b0 : lsbq[0];
        lsbq <= lsbq >> 1;
      end
    end
  end

  // falling-edge side: launch onto the pins
  always_ff @(negedge clk or posedge cs_n) begin
    if (cs_n) begin
      do_en  <= 1'b0;
      do_val <= 1'b0;
    end else begin
      do_en  <= oe_r;
      do_val <= dv_r;
    end
  end

  // R5: the line comes up carrying the leading zero
  p_lead_zero_r5: assert property (@(posedge clk) disable iff (cs_n)
    $rose(oe_r) |-> !dv_r);

  // R8: a held shift phase leaves the line alone
  p_hold_se_r8: assert property (@(posedge clk) disable iff (cs_n)
    ((phase == ST_SHIFT) && !adv) |=> $stable(dv_r));

  // R9: after the last bit the driven line is low
  p_done_low_r9: assert property (@(posedge clk) disable iff (cs_n)
    (phase == ST_DONE) |-> (oe_r && !dv_r));

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sarseq_pkg::*;
#(
  parameter int        W        = 8,
  parameter int        CH_W     = 3,
  parameter int        SAMP_CYC = 1,
  parameter lsb_mode_e MODE     = LSB_PACED
) (
  input  logic            clk,
  input  logic            cs_n,
  input  logic            di,
  input  logic            comp,
  input  logic            se,
  output logic            sars,
  output logic            do_en,
  output logic            do_val,
  output logic [CH_W-1:0] chan_code,
  output logic [W-1:0]    trial_code
);

  localparam int BW = $clog2(W);

  phase_e        phase;
  logic [BW-1:0] bidx;
  logic          lock;
  logic          take;
  logic          go_conv;
  logic          conv;
  logic          last_step;
  logic          adv;
  logic          fin_shift;
  logic [W-2:0]  upper;

  sarseq_addr_rx #(.CH_W(CH_W)) u_addr (
    .clk (clk),
    .cs_n(cs_n),
    .take(take),
    .di  (di),
    .lock(lock),
    .chan(chan_code)
  );

  sarseq_fsm #(.W(W), .BW(BW), .SAMP_CYC(SAMP_CYC), .MODE(MODE)) u_fsm (
    .clk      (clk),
    .cs_n     (cs_n),
    .lock     (lock),
    .se       (se),
    .phase    (phase),
    .bidx     (bidx),
    .sars     (sars),
    .take     (take),
    .go_conv  (go_conv),
    .conv     (conv),
    .last_step(last_step),
    .adv      (adv),
    .fin_shift(fin_shift)
  );

  sarseq_sar #(.W(W), .BW(BW)) u_sar (
    .clk  (clk),
    .cs_n (cs_n),
    .conv (conv),
    .bidx (bidx),
    .comp (comp),
    .trial(trial_code),
    .upper(upper)
  );

  sarseq_dout #(.W(W), .MODE(MODE)) u_dout (
    .clk      (clk),
    .cs_n     (cs_n),
    .phase    (phase),
    .go_conv  (go_conv),
    .last_step(last_step),
    .comp     (comp),
    .upper    (upper),
    .adv      (adv),
    .fin_shift(fin_shift),
    .do_en    (do_en),
    .do_val   (do_val)
  );

endmodule

// File: tb/test_sar_serial_seq.sv
module test_sar_serial_seq;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       cs_n, di, se;
  logic [7:0] vin;

  logic       sars_p, sars_a, sars_m;
  logic       en_p, en_a, en_m;
  logic       dv_p, dv_a, dv_m;
  logic [2:0] ch_p, ch_a, ch_m;
  logic [7:0] tr_p, tr_a, tr_m;
  logic       cmp_p, cmp_a, cmp_m;

  // comparator model: high when the input is at or above the trial code
  assign cmp_p = (vin >= tr_p);
  assign cmp_a = (vin >= tr_a);
  assign cmp_m = (vin >= tr_m);

  sar_serial_seq #(.MODE(sarseq_pkg::LSB_PACED)) i_sar_serial_seq (
    .clk(clk), .cs_n(cs_n), .di(di), .comp(cmp_p), .se(se), .sars(sars_p),
    .do_en(en_p), .do_val(dv_p), .chan_code(ch_p), .trial_code(tr_p));

  sar_serial_seq #(.MODE(sarseq_pkg::LSB_AUTO)) i_sar_serial_seq_auto (
    .clk(clk), .cs_n(cs_n), .di(di), .comp(cmp_a), .se(se), .sars(sars_a),
    .do_en(en_a), .do_val(dv_a), .chan_code(ch_a), .trial_code(tr_a));

  sar_serial_seq #(.MODE(sarseq_pkg::MSB_ONLY)) i_sar_serial_seq_msb (
    .clk(clk), .cs_n(cs_n), .di(di), .comp(cmp_m), .se(se), .sars(sars_m),
    .do_en(en_m), .do_val(dv_m), .chan_code(ch_m), .trial_code(tr_m));

  typedef struct {
    logic       en;
    logic [2:0] dv;    // paced, auto, msb-only
    logic       sars;
    logic [7:0] trial;
    logic [2:0] chan;
    int         t_en, t_dv, t_sars, t_tr, t_ch;  // t_dv 0 = per-mode tag
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  task automatic chk(int tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: samples after each falling edge and scores against the queue
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.t_en, "do_en paced", 8'(en_p), 8'(e.en));
        chk(e.t_en, "do_en auto",  8'(en_a), 8'(e.en));
        chk(e.t_en, "do_en msb",   8'(en_m), 8'(e.en));
        if (e.en) begin
          chk((e.t_dv != 0) ? e.t_dv : 8,  "do_val paced", 8'(dv_p), 8'(e.dv[0]));
          chk((e.t_dv != 0) ? e.t_dv : 9,  "do_val auto",  8'(dv_a), 8'(e.dv[1]));
          chk((e.t_dv != 0) ? e.t_dv : 10, "do_val msb",   8'(dv_m), 8'(e.dv[2]));
        end
        chk(e.t_sars, "sars paced", 8'(sars_p), 8'(e.sars));
        chk(e.t_sars, "sars auto",  8'(sars_a), 8'(e.sars));
        chk(e.t_sars, "sars msb",   8'(sars_m), 8'(e.sars));
        chk(e.t_tr, "trial paced", tr_p, e.trial);
        chk(e.t_tr, "trial auto",  tr_a, e.trial);
        chk(e.t_tr, "trial msb",   tr_m, e.trial);
        chk(e.t_ch, "chan paced", 8'(ch_p), 8'(e.chan));
        chk(e.t_ch, "chan auto",  8'(ch_a), 8'(e.chan));
        chk(e.t_ch, "chan msb",   8'(ch_m), 8'(e.chan));
      end
    end
  end

  function automatic exp_t cleared();
    exp_t e;
    e.en = 0; e.dv = '0; e.sars = 0; e.trial = '0; e.chan = '0;
    // R11: everything reads as cleared while deselected
    e.t_en = 11; e.t_dv = 11; e.t_sars = 11; e.t_tr = 11; e.t_ch = 11;
    return e;
  endfunction

  // R6: decided bits above i, a one at i, zeros below
  function automatic logic [7:0] trial_exp(logic [7:0] v, int i);
    logic [7:0] keep;
    keep = 8'hFF << (i + 1);
    return (v & keep) | (8'h01 << i);
  endfunction

  // driver: one clock of stimulus; expectation pushed after the rising edge
  task automatic cycle(logic c, logic d, logic s, exp_t e);
    @(negedge clk);
    #7;
    cs_n = c;
    di   = d;
    se   = s;
    @(posedge clk);
    #1;
    q.push_back(e);
  endtask

  task automatic run(int ch, logic [7:0] v, int nz, int se_hold, int abort_at, int ncyc);
    int L;
    int advs;
    L    = nz + 4;  // clock that samples the last channel bit
    advs = 0;
    vin  = v;
    for (int k = 1; k <= ncyc; k++) begin
      exp_t e;
      logic c, d, s;
      c = (abort_at > 0) && (k >= abort_at);
      // R1: leading zeros, start bit, channel MSB first; R4: junk afterwards
      if (k <= nz)          d = 1'b0;
      else if (k == nz + 1) d = 1'b1;
      else if (k <= nz + 4) d = 1'((ch >> (nz + 4 - k)) & 1);
      else                  d = 1'($urandom);
      // R8: se random (no effect) until shifting may begin
      if (k < L + 10) s = 1'($urandom);
      else            s = (k < L + 10 + se_hold);
      if (k >= L + 10 && !s) advs++;
      if (c) begin
        e = cleared();
      end else begin
        e.chan  = (k >= L) ? 3'(ch) : 3'd0;
        e.t_ch  = (k > L) ? 4 : 1;
        e.sars  = (k >= L + 1) && (k <= L + 9);
        e.t_sars = (k <= L + 1) ? 2 : 3;
        e.trial = (k >= L + 1 && k <= L + 8) ? trial_exp(v, 7 - (k - L - 1)) : 8'h00;
        e.t_tr  = 6;
        e.en    = (k >= L + 1);
        e.t_en  = 5;
        if (k <= L + 1) begin
          e.dv = 3'b000;          // R5 leading zero
          e.t_dv = 5;
        end else if (k <= L + 9) begin
          e.dv = {3{v[7 - (k - L - 2)]}};  // R7 MSB-first stream
          e.t_dv = 7;
        end else begin
          int j;
          j = k - L - 10;
          e.dv[0] = (advs == 0) ? v[0] : (advs <= 7) ? v[advs] : 1'b0;  // R8
          e.dv[1] = (j <= 6) ? v[1 + j] : 1'b0;                           // R9
          e.dv[2] = 1'b0;                                                 // R10
          e.t_dv = 0;
        end
      end
      cycle(c, d, s, e);
    end
    cycle(1'b1, 1'b0, 1'b1, cleared());
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cs_n = 1'b0;
    di   = 1'b0;
    se   = 1'b1;
    vin  = 8'h00;
    #2 cs_n = 1'b1;
    // reset state (R11)
    cycle(1'b1, 1'b0, 1'b1, cleared());
    cycle(1'b1, 1'b1, 1'b0, cleared());
    run(5, 8'hA5, 0, 3, 0, 40);
    run(2, 8'h00, 2, 0, 0, 40);
    run(7, 8'hFF, 1, 30, 0, 40);
    run(0, 8'h3C, 0, 2, 9, 40);    // aborted mid-conversion (R11)
    run(6, 8'h5A, 0, 1, 0, 40);    // fresh address after abort
    run(3, 8'h81, 36, 0, 0, 40);   // long zero preamble (R1)
    for (int r = 0; r < 4; r++) begin
      run(int'($urandom % 8), 8'($urandom), int'($urandom % 3),
          int'($urandom % 5), 0, 40);
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule